// File: doc/BRIEF.md
# Prioritised Interrupt Vector Generator

This block gathers eighteen interrupt sources from a data converter into one request line and one 16-bit vector word. Two of the sources are overflow conditions: one for a result that was overwritten before it was read, and one for a conversion that ran past its time limit. The other sixteen are completion flags, one per result slot. Each source latches into a sticky flag and has its own enable bit. A global gate input masks every request at once.

The vector names the pending, enabled source with the lowest code. Codes rise in steps of two, and zero means that nothing is pending. When the vector is read, the flag behind the reported code is cleared, and the next pending source shows up one cycle later. A flag-write port and an enable-write port let the owning processor load both registers directly. An event that arrives in the same cycle as a clear of its flag always wins, so no event is lost.

Top module: `ivg_top`

## Requirements
- R1: After reset all flags and enables are zero, `vecOut` is 0x0000 and `irqOut` is low.
- R2: Flag bit 0 (result overwrite) reports as 0x0002, flag bit 1 (conversion time overrun) reports as 0x0004, and flag bit 2+n (completion of slot n, n = 0..15) reports as 0x0006 + 2n, so slot 15 reports 0x0024. With nothing reportable the vector is 0x0000.
- R3: When several enabled flags are pending, the one with the lowest flag bit index (lowest code) is reported. Both overflow sources therefore beat every slot.
- R4: A pending flag whose enable bit is zero is never reported, but it stays latched in `flagsOut`.
- R5: While `gateEn` is low, `vecOut` is 0x0000 and `irqOut` is low. Events are still latched, and they are reported once the gate rises.
- R6: `irqOut` is high exactly when `vecOut` is non-zero.
- R7: A `vecRd` pulse while the vector is non-zero clears only the flag that was reported. The next pending source appears on the vector in the following cycle.
- R8: A `vecRd` pulse while the vector is 0x0000 leaves every flag unchanged.
- R9: An event on `evtIn` sets its flag on the next clock edge, even when a vector read or a flag write clears that same flag in that cycle.
- R10: A `flagWrEn` pulse loads `flagWrData` into the flags, with events of the same cycle OR-ed on top. Flag write takes precedence over a vector read in the same cycle.
- R11: An `enWrEn` pulse loads `enWrData` into the enable bits, which use the same bit layout as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateEn | input | 1 | Global interrupt gate |
| evtIn | input | 18 | One-cycle event pulses; bit 0 overwrite, bit 1 time overrun, bit 2+n slot n |
| flagWrEn | input | 1 | Load strobe for the flag register |
| flagWrData | input | 18 | Flag load value |
| enWrEn | input | 1 | Load strobe for the enable register |
| enWrData | input | 18 | Enable load value |
| vecRd | input | 1 | Vector read strobe (acknowledge) |
| irqOut | output | 1 | Interrupt request |
| vecOut | output | 16 | Vector code of the highest-priority pending enabled source |
| flagsOut | output | 18 | Current sticky flags |

## Verification
The bench aims at the ordering and collision cases. These are reads that drain a full set of flags one code at a time, an event that lands on the flag being acknowledged, a flag write in the same cycle as a read, and reads issued while nothing is pending. If the priority scan were reversed, slot 15 would be reported ahead of the overflow sources. If the clear took precedence over the set, the collision event would vanish and the flag would read zero. If a read with an empty vector decoded a stale index, it would knock out a masked or gated flag. Masked and gated flags are checked at `flagsOut` to show that they were held rather than dropped.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  // Width of a source index; covers up to 32 sources.
  localparam int unsigned IDX_W = 5;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic             flagLoad;
    logic             enLoad;
    logic             ackValid;
    logic [IDX_W-1:0] ackIdx;
  } ivg_strobe_t;
endpackage

// File: rtl/ivg_ctrl.sv
module ivg_ctrl
  import ivg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 18,
  parameter int unsigned VEC_W   = 16
) (
  input  logic [NUM_SRC-1:0] flagsQ,
  input  logic [NUM_SRC-1:0] enQ,
  input  logic               gateEn,
  input  logic               flagWrEn,
  input  logic               enWrEn,
  input  logic               vecRd,
  output ivg_strobe_t        strb,
  output logic [VEC_W-1:0]   vecCode
);
  logic [NUM_SRC-1:0] pending;
  logic               found;
  logic [IDX_W-1:0]   winIdx;

  assign pending = flagsQ & enQ & {NUM_SRC{gateEn}};

  // Scan from the top down so that the lowest index is the last to win.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  // Code = 2 * (index + 1); zero when idle.
  assign vecCode = found ? (VEC_W'({winIdx, 1'b0}) + VEC_W'(2)) : '0;

  always_comb begin
    strb.flagLoad = flagWrEn;
    strb.enLoad   = enWrEn;
    strb.ackValid = vecRd & found;
    strb.ackIdx   = winIdx;
  end
endmodule

// File: rtl/ivg_datapath.sv
module ivg_datapath
  import ivg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  ivg_strobe_t        strb,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_SRC-1:0] flagWrData,
  input  logic [NUM_SRC-1:0] enWrData,
  output logic [NUM_SRC-1:0] flagsQ,
  output logic [NUM_SRC-1:0] enQ
);
  // One sticky cell per source: load, then clear, then set (set wins).
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    logic ackHit;
    logic baseVal;
    assign ackHit  = strb.ackValid && (strb.ackIdx == IDX_W'(g));
    assign baseVal = strb.flagLoad ? flagWrData[g] : (flagsQ[g] & ~ackHit);

    always_ff @(posedge clk) begin
      if (!rstN) flagsQ[g] <= 1'b0;
      else       flagsQ[g] <= baseVal | evtIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            enQ <= '0;
    else if (strb.enLoad) enQ <= enWrData;
  end
endmodule

// File: rtl/ivg_top.sv
module ivg_top
  import ivg_pkg::*;
#(
  parameter int unsigned NUM_OVF   = 2,
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned VEC_W     = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           gateEn,
  input  logic [NUM_OVF+NUM_SLOTS-1:0]   evtIn,
  input  logic                           flagWrEn,
  input  logic [NUM_OVF+NUM_SLOTS-1:0]   flagWrData,
  input  logic                           enWrEn,
  input  logic [NUM_OVF+NUM_SLOTS-1:0]   enWrData,
  input  logic                           vecRd,
  output logic                           irqOut,
  output logic [VEC_W-1:0]               vecOut,
  output logic [NUM_OVF+NUM_SLOTS-1:0]   flagsOut
);
  localparam int unsigned NUM_SRC = NUM_OVF + NUM_SLOTS;

  ivg_strobe_t        strb;
  logic [NUM_SRC-1:0] flagsQ;
  logic [NUM_SRC-1:0] enReg;

  ivg_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ctrl (
    .flagsQ  (flagsQ),
    .enQ     (enReg),
    .gateEn  (gateEn),
    .flagWrEn(flagWrEn),
    .enWrEn  (enWrEn),
    .vecRd   (vecRd),
    .strb    (strb),
    .vecCode (vecOut)
  );

  ivg_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evtIn     (evtIn),
    .flagWrData(flagWrData),
    .enWrData  (enWrData),
    .flagsQ    (flagsQ),
    .enQ       (enReg)
  );

  assign irqOut   = |vecOut;
  assign flagsOut = flagsQ;
endmodule

// File: rtl/ivg_checker.sv
module ivg_checker
  import ivg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 18,
  parameter int unsigned VEC_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               gateEn,
  input logic [NUM_SRC-1:0] evtIn,
  input logic               flagWrEn,
  input logic               vecRd,
  input logic               irqOut,
  input logic [VEC_W-1:0]   vecOut,
  input logic [NUM_SRC-1:0] flagsOut,
  input logic [NUM_SRC-1:0] enables
);
  logic [IDX_W-1:0]   repIdx;
  logic [NUM_SRC-1:0] lowerMask;
  logic [VEC_W-1:0]   halfVec;

  assign halfVec   = vecOut >> 1;
  assign repIdx    = (vecOut == '0) ? '0 : IDX_W'(halfVec - VEC_W'(1));
  assign lowerMask = (NUM_SRC'(1) << repIdx) - NUM_SRC'(1);

  AST_GATE_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> (vecOut == '0 && !irqOut)); // R5

  AST_CODE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut[0] == 1'b0) && (vecOut <= VEC_W'(2 * NUM_SRC))); // R2

  AST_REPORTED_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut != '0) |-> (flagsOut[repIdx] && enables[repIdx])); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut != '0) |-> ((flagsOut & enables & lowerMask) == '0)); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && vecOut != '0 && !flagWrEn && !evtIn[repIdx]) |=> !flagsOut[$past(repIdx)]); // R7

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((flagsOut & $past(evtIn)) == $past(evtIn))); // R9

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && vecOut == '0 && !flagWrEn && evtIn == '0) |=> $stable(flagsOut)); // R8
endmodule

bind ivg_top ivg_checker #(.NUM_SRC(NUM_OVF + NUM_SLOTS), .VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .gateEn  (gateEn),
  .evtIn   (evtIn),
  .flagWrEn(flagWrEn),
  .vecRd   (vecRd),
  .irqOut  (irqOut),
  .vecOut  (vecOut),
  .flagsOut(flagsOut),
  .enables (enReg)
);

// File: tb/tb_ivg_top.sv
module tb_ivg_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateEn = 1'b0;
  logic [NSRC-1:0] evtIn = '0;
  logic flagWrEn = 1'b0;
  logic [NSRC-1:0] flagWrData = '0;
  logic enWrEn = 1'b0;
  logic [NSRC-1:0] enWrData = '0;
  logic vecRd = 1'b0;
  logic irqOut;
  logic [15:0] vecOut;
  logic [NSRC-1:0] flagsOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural reference state.
  bit [NSRC-1:0] mFlags = '0;
  bit [NSRC-1:0] mEns = '0;

  ivg_top dut (
    .clk(clk), .rstN(rstN), .gateEn(gateEn), .evtIn(evtIn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .enWrEn(enWrEn),
    .enWrData(enWrData), .vecRd(vecRd), .irqOut(irqOut),
    .vecOut(vecOut), .flagsOut(flagsOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int modelVec();
    if (!gateEn) return 0;
    for (int i = 0; i < NSRC; i++)
      if (mFlags[i] && mEns[i]) return 2 * (i + 1);
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Compare, clock once, advance the model, release pulses.
  task automatic tick();
    int v;
    #1;
    v = modelVec();
    check({curReq, " vec"}, int'(vecOut), v);
    check("R6 irq", int'(irqOut), (v != 0) ? 1 : 0);
    check({curReq, " flags"}, int'(flagsOut), int'(mFlags));
    @(posedge clk);
    if (!rstN) begin
      mFlags = '0;
      mEns = '0;
    end else begin
      bit [NSRC-1:0] nf;
      nf = mFlags;
      if (flagWrEn) nf = flagWrData;
      else if (vecRd && v != 0) nf[v / 2 - 1] = 1'b0;
      mFlags = nf | evtIn;
      if (enWrEn) mEns = enWrData;
    end
    @(negedge clk);
    evtIn = '0; flagWrEn = 0; enWrEn = 0; vecRd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    curReq = "R1";
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    check("R1 reset vec", int'(vecOut), 0);
    check("R1 reset flags", int'(flagsOut), 0);

    // R11: enable all, gate on
    curReq = "R11";
    enWrEn = 1; enWrData = '1; gateEn = 1;
    tick();

    // R2: slot 15 alone
    curReq = "R2";
    evtIn = 18'h1 << 17; tick();
    #1 check("R2 slot15 code", int'(vecOut), 16'h0024);
    vecRd = 1; tick();

    // R2/R7: every source alone, then acknowledged
    for (int i = 0; i < NSRC; i++) begin
      curReq = "R2";
      evtIn = 18'h1 << i; tick();
      #1 check("R2 single code", int'(vecOut), 2 * (i + 1));
      curReq = "R7";
      vecRd = 1; tick();
      #1 check("R7 cleared", int'(flagsOut), 0);
    end

    // R3: all pending, drain in ascending order
    curReq = "R3";
    evtIn = '1; tick();
    #1 check("R3 overwrite first", int'(vecOut), 16'h0002);
    for (int i = 0; i < NSRC; i++) begin
      #1 check("R3 drain order", int'(vecOut), 2 * (i + 1));
      curReq = "R7";
      vecRd = 1; tick();
    end

    // R4 / R11: mask slot 0, events on slot 0 and slot 4
    curReq = "R4";
    enWrEn = 1; enWrData = ~(18'h1 << 2); tick();
    evtIn = (18'h1 << 2) | (18'h1 << 6); tick();
    #1 check("R4 masked skipped", int'(vecOut), 16'h000E);
    check("R4 masked held", int'(flagsOut[2]), 1);
    vecRd = 1; tick();
    #1 check("R4 masked not reported", int'(vecOut), 0);
    enWrEn = 1; enWrData = '1; tick();
    #1 check("R11 unmasked", int'(vecOut), 16'h0006);
    vecRd = 1; tick();

    // R5: gate low
    curReq = "R5";
    gateEn = 0; evtIn = 18'h2; tick();
    #1 check("R5 gated vec", int'(vecOut), 0);
    check("R5 gated irq", int'(irqOut), 0);
    check("R5 latched", int'(flagsOut), 2);
    // R8: read while idle (gated) has no effect
    curReq = "R8";
    vecRd = 1; tick();
    #1 check("R8 idle read", int'(flagsOut), 2);
    curReq = "R5";
    gateEn = 1; tick();
    #1 check("R5 released", int'(vecOut), 16'h0004);

    // R9: event on the acknowledged flag in the same cycle
    curReq = "R9";
    vecRd = 1; evtIn = 18'h2; tick();
    #1 check("R9 set wins", int'(flagsOut), 2);
    vecRd = 1; tick();

    // R10: flag write, with read and event in same cycle
    curReq = "R10";
    flagWrEn = 1; flagWrData = 18'h00030; tick();
    #1 check("R10 loaded", int'(flagsOut), 18'h00030);
    flagWrEn = 1; flagWrData = 18'h00030; vecRd = 1; evtIn = 18'h1; tick();
    #1 check("R10 write beats read", int'(flagsOut), 18'h00031);
    flagWrEn = 1; flagWrData = '0; evtIn = 18'h8; tick();
    #1 check("R9 event beats write", int'(flagsOut), 18'h00008);
    curReq = "R7";
    repeat (3) begin vecRd = 1; tick(); end
    #1 check("R7 all drained", int'(flagsOut), 0);

    // R1: reset again clears enables
    curReq = "R1";
    evtIn = '1; tick();
    rstN = 0; tick();
    rstN = 1; evtIn = 18'h1; tick();
    #1 check("R1 enables cleared", int'(vecOut), 0);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule